// File: doc/BRIEF.md
# Multi-Mode Serial Port Controller

This block is a byte-wide serial port that works in one of four modes picked by a 2-bit mode input. Mode 0 is a synchronous shifter. On each write it sends one byte on the data line and drives a shift clock on the transmit line, at one bit per machine cycle of 12 clocks. Mode 1 is a 10-bit asynchronous link. Modes 2 and 3 are 11-bit asynchronous links that carry an extra ninth bit. Modes 2 and 3 differ only in where their bit rate comes from.

One `clk` period stands for one oscillator period. The bit rate comes from one of two sources:
- Mode 2 uses a fixed division of the oscillator.
- Modes 1 and 3 use the overflow rate of an 8-bit auto-reload timer. The timer advances once per machine cycle.

A rate-doubling input shortens both sources. The receiver is an oversampling design, and a receive-enable input gates it. The receiver and the transmitter each have a completion flag. A flag stays raised until its clear strobe is pulsed.

Top module: `serial_port_ctl`

## Requirements
- R1: After reset the following hold: `txd_o`=1, `rxd_o`=1, `rxd_oe_o`=0, both flags 0, and `rx_data_o`=0.
- R2: In mode 0 (`mode_i`=0), a write sends the 8 data bits LSB first on `rxd_o`, with `rxd_oe_o`=1 while it sends. `txd_o` carries a shift clock with one rising edge per bit, 12 clocks apart. Data is valid at each rising edge. `tx_flag_o` rises once the eighth bit ends.
- R3: Mode 1 (`mode_i`=1) sends a 10-bit frame on `txd_o`: a low start bit, 8 data bits LSB first, then a high stop bit. The receiver accepts the same frame on `rxd_i`.
- R4: Modes 2 and 3 (`mode_i`=2, 3) use an 11-bit frame: start bit, 8 data bits LSB first, a ninth bit, then the stop bit. On transmit the ninth bit is `tx_bit9_i`. On receive it goes to `rx_bit9_o`. A mode 1 reception leaves `rx_bit9_o` unchanged.
- R5: The mode 2 bit time is 64 clocks with `dbl_rate_i`=0 and 32 clocks with `dbl_rate_i`=1.
- R6: The mode 1 and mode 3 bit time is 12*(256-N)*32/2^`dbl_rate_i` clocks, where N is `reload_i`. The timer reloads N by itself on each overflow.
- R7: `tx_flag_o` rises at the start of the transmitted stop bit. `rx_flag_o` rises at mid-stop-bit of an accepted frame. Each flag stays high until its clear strobe is pulsed, and falls the clock after that strobe.
- R8: The receiver takes 16 samples per bit and decides each bit by majority of the three middle samples. A low pulse shorter than half a bit is rejected as a false start, and a frame that follows it is received normally.
- R9: A received frame whose stop bit is low is dropped: `rx_flag_o` stays 0 and `rx_data_o` is unchanged.
- R10: No reception starts while `rx_en_i`=0 or while `mode_i`=0. Frames on `rxd_i` then leave `rx_flag_o` and `rx_data_o` unchanged.
- R11: A write strobe during a transmission is ignored. The frame in flight completes unchanged and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode select (0 shift, 1 10-bit, 2 11-bit fixed rate, 3 11-bit timer rate) |
| dbl_rate_i | input | 1 | Doubles the bit rate of the asynchronous modes |
| reload_i | input | 8 | Timer reload value N |
| rx_en_i | input | 1 | Allows new receptions |
| tx_wr_i | input | 1 | Write strobe: loads `tx_data_i` and starts a transmission |
| tx_data_i | input | 8 | Byte to transmit |
| tx_bit9_i | input | 1 | Ninth bit sent in modes 2 and 3 |
| tx_flag_clr_i | input | 1 | Clears `tx_flag_o` |
| rx_flag_clr_i | input | 1 | Clears `rx_flag_o` |
| rxd_i | input | 1 | Asynchronous serial input |
| txd_o | output | 1 | Asynchronous serial output; shift clock in mode 0 |
| rxd_o | output | 1 | Mode 0 data output |
| rxd_oe_o | output | 1 | Drive enable for `rxd_o` |
| rx_data_o | output | 8 | Last accepted received byte |
| rx_bit9_o | output | 1 | Last received ninth bit |
| tx_flag_o | output | 1 | Transmit completion flag |
| rx_flag_o | output | 1 | Receive completion flag |

## Verification
The assertions assume three things about the inputs:
- `mode_i`, `dbl_rate_i` and `reload_i` change only while no frame is in flight.
- Clear strobes are single-cycle pulses.
- Any frame on `rxd_i` keeps to the bit time that the current settings imply.

The stimulus changes the configuration only between frames. After a change of reload value it waits long enough for the timer to pass through a full reload period. It builds every receive frame, including the false-start glitch and the low stop bit, from its own computed bit time. It decodes transmitted frames by timing from the falling edge of the start bit. That makes its checks independent of the phase of the rate dividers.

// File: rtl/serial_pkg.sv
package serial_pkg;
   typedef enum logic [1:0] {
      MODE_SHIFT    = 2'd0,
      MODE_ASYNC10  = 2'd1,
      MODE_ASYNC11F = 2'd2,
      MODE_ASYNC11T = 2'd3
   } ser_mode_e;
endpackage

// File: rtl/serial_baud.sv
module serial_baud
   import serial_pkg::*;
#(
   parameter int MC_DIV  = 12,
   parameter int TMR_W   = 8,
   parameter int OVS     = 16,
   parameter int FIX_DIV = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ser_mode_e        mode,
   input  logic             dbl,
   input  logic [TMR_W-1:0] reload,
   output logic             tick
);
   localparam int MCW   = $clog2(MC_DIV);
   localparam int FIX_T = FIX_DIV / OVS;
   localparam int FXW   = $clog2(FIX_T);

   logic [MCW-1:0]   mc_cnt;
   logic [TMR_W-1:0] tmr;
   logic [FXW-1:0]   fix_cnt;
   logic             half;
   logic             mc_tick, ovf, tmr_tick, fix_tick;

   assign mc_tick  = (mc_cnt == MCW'(MC_DIV - 1));
   assign ovf      = mc_tick & (&tmr);
   assign tmr_tick = ovf & (dbl | half);
   assign fix_tick = dbl ? (&fix_cnt[FXW-2:0]) : (&fix_cnt);
   assign tick     = (mode == MODE_ASYNC11F) ? fix_tick : tmr_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mc_cnt  <= '0;
         tmr     <= '0;
         fix_cnt <= '0;
         half    <= 1'b0;
      end else begin
         fix_cnt <= fix_cnt + 1'b1;
         mc_cnt  <= mc_tick ? '0 : mc_cnt + 1'b1;
         if (mc_tick) tmr <= (&tmr) ? reload : tmr + 1'b1;
         if (ovf) half <= ~half;
      end
   end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
   import serial_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter int MC_DIV = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ser_mode_e         mode,
   input  logic              tick,
   input  logic              wr,
   input  logic [DATA_W-1:0] data,
   input  logic              bit9,
   input  logic              flag_clr,
   output logic              txd,
   output logic              dout,
   output logic              doe,
   output logic              flag,
   output logic              busy
);
   localparam int FW  = DATA_W + 3;
   localparam int BW  = $clog2(FW + 1);
   localparam int TCW = $clog2((MC_DIV > OVS) ? MC_DIV : OVS);

   logic [FW-1:0]  sh;
   logic [BW-1:0]  bleft;
   logic [TCW-1:0] tcnt;
   logic           m0;

   assign doe  = busy & m0;
   assign dout = doe ? sh[0] : 1'b1;
   assign txd  = !busy ? 1'b1 : (m0 ? (tcnt >= TCW'(MC_DIV / 2)) : sh[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '1;
         bleft <= '0;
         tcnt  <= '0;
         m0    <= 1'b0;
         busy  <= 1'b0;
         flag  <= 1'b0;
      end else begin
         if (flag_clr) flag <= 1'b0;
         if (!busy) begin
            if (wr) begin
               busy <= 1'b1;
               tcnt <= '0;
               m0   <= (mode == MODE_SHIFT);
               case (mode)
                  MODE_SHIFT: begin
                     sh    <= {3'b111, data};
                     bleft <= BW'(DATA_W);
                  end
                  MODE_ASYNC10: begin
                     sh    <= {2'b11, data, 1'b0};
                     bleft <= BW'(DATA_W + 2);
                  end
                  default: begin
                     sh    <= {1'b1, bit9, data, 1'b0};
                     bleft <= BW'(DATA_W + 3);
                  end
               endcase
            end
         end else if (m0) begin
            if (tcnt == TCW'(MC_DIV - 1)) begin
               tcnt  <= '0;
               sh    <= {1'b1, sh[FW-1:1]};
               bleft <= bleft - 1'b1;
               if (bleft == BW'(1)) begin
                  busy <= 1'b0;
                  flag <= 1'b1;
               end
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end else if (tick) begin
            if (tcnt == TCW'(OVS - 1)) begin
               tcnt  <= '0;
               sh    <= {1'b1, sh[FW-1:1]};
               bleft <= bleft - 1'b1;
               if (bleft == BW'(2)) flag <= 1'b1;
               if (bleft == BW'(1)) busy <= 1'b0;
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
   import serial_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ser_mode_e         mode,
   input  logic              tick,
   input  logic              en,
   input  logic              rxs,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] data,
   output logic              bit9,
   output logic              flag
);
   localparam int SW  = $clog2(OVS);
   localparam int BW  = $clog2(DATA_W + 4);
   localparam int MID = OVS / 2;

   logic [SW-1:0]     scnt, scnt_nx;
   logic [BW-1:0]     bidx, stop_idx;
   logic [DATA_W-1:0] dsh;
   logic              act, ten, s_a, s_b, n9, last_hi, vote;

   assign scnt_nx  = scnt + 1'b1;
   assign stop_idx = ten ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
   assign vote     = (s_a & s_b) | (s_a & rxs) | (s_b & rxs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scnt    <= '0;
         bidx    <= '0;
         dsh     <= '0;
         data    <= '0;
         act     <= 1'b0;
         ten     <= 1'b0;
         s_a     <= 1'b1;
         s_b     <= 1'b1;
         n9      <= 1'b0;
         bit9    <= 1'b0;
         last_hi <= 1'b1;
         flag    <= 1'b0;
      end else begin
         if (flag_clr) flag <= 1'b0;
         if (tick) begin
            last_hi <= rxs;
            if (!act) begin
               if (en && mode != MODE_SHIFT && last_hi && !rxs) begin
                  act  <= 1'b1;
                  scnt <= '0;
                  bidx <= '0;
                  ten  <= (mode != MODE_ASYNC10);
               end
            end else begin
               scnt <= scnt_nx;
               if (scnt_nx == SW'(MID - 1)) s_a <= rxs;
               if (scnt_nx == SW'(MID)) s_b <= rxs;
               if (scnt_nx == SW'(MID + 1)) begin
                  if (bidx == '0) begin
                     if (vote) act <= 1'b0;
                  end else if (bidx == stop_idx) begin
                     act <= 1'b0;
                     if (vote) begin
                        data <= dsh;
                        flag <= 1'b1;
                        if (ten) bit9 <= n9;
                     end
                  end else if (bidx == BW'(DATA_W + 1)) begin
                     n9 <= vote;
                  end else begin
                     dsh <= {vote, dsh[DATA_W-1:1]};
                  end
               end
               if (scnt_nx == '0) bidx <= bidx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/serial_port_ctl.sv
module serial_port_ctl
   import serial_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TMR_W       = 8,
   parameter int MC_DIV      = 12,
   parameter int OVS         = 16,
   parameter int FIX_DIV     = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              dbl_rate_i,
   input  logic [TMR_W-1:0]  reload_i,
   input  logic              rx_en_i,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_bit9_i,
   input  logic              tx_flag_clr_i,
   input  logic              rx_flag_clr_i,
   input  logic              rxd_i,
   output logic              txd_o,
   output logic              rxd_o,
   output logic              rxd_oe_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_bit9_o,
   output logic              tx_flag_o,
   output logic              rx_flag_o
);
   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 4");
   end
   if ((FIX_DIV % (2 * OVS)) != 0 || ((FIX_DIV / OVS) & (FIX_DIV / OVS - 1)) != 0) begin : g_bad_fix
      $error("FIX_DIV/OVS must be a power of two of at least 2");
   end
   if (MC_DIV < 2 || (MC_DIV % 2) != 0) begin : g_bad_mc
      $error("MC_DIV must be even and at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   ser_mode_e              mode_e;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   tick, tx_busy;

   assign mode_e = ser_mode_e'(mode_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
   end

   serial_baud #(.MC_DIV(MC_DIV), .TMR_W(TMR_W), .OVS(OVS), .FIX_DIV(FIX_DIV)) i_baud (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .dbl(dbl_rate_i),
      .reload(reload_i), .tick(tick)
   );

   serial_tx #(.DATA_W(DATA_W), .OVS(OVS), .MC_DIV(MC_DIV)) i_tx (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .tick(tick), .wr(tx_wr_i),
      .data(tx_data_i), .bit9(tx_bit9_i), .flag_clr(tx_flag_clr_i),
      .txd(txd_o), .dout(rxd_o), .doe(rxd_oe_o), .flag(tx_flag_o), .busy(tx_busy)
   );

   serial_rx #(.DATA_W(DATA_W), .OVS(OVS)) i_rx (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .tick(tick), .en(rx_en_i),
      .rxs(sync_q[SYNC_STAGES-1]), .flag_clr(rx_flag_clr_i),
      .data(rx_data_o), .bit9(rx_bit9_o), .flag(rx_flag_o)
   );
endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_i,
   input logic              txd_o,
   input logic              rxd_oe_o,
   input logic              tx_flag_o,
   input logic              tx_flag_clr_i,
   input logic              rx_flag_o,
   input logic              rx_flag_clr_i,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              tx_busy
);
   // R1: line rests high whenever the transmitter is idle
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd_o);

   // R2: data line is driven only in shift mode
   a_r2_oe_shift_only: assert property (@(posedge clk) disable iff (!rst_n)
      rxd_oe_o |-> (mode_i == 2'd0));

   // R7: flags hold until cleared
   a_r7_ti_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flag_o && !tx_flag_clr_i) |=> tx_flag_o);

   a_r7_ri_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag_o && !rx_flag_clr_i) |=> rx_flag_o);

   // R7: clearing an idle transmitter's flag takes effect next cycle
   a_r7_ti_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flag_clr_i && !tx_busy) |=> !tx_flag_o);

   // R9: received byte changes only together with an accepted frame
   a_r9_data_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data_o) |-> rx_flag_o);

   // R10: no reception completes in shift mode
   a_r10_no_rx_shift: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag_o) |-> (mode_i != 2'd0));
endmodule

bind serial_port_ctl serial_port_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .txd_o(txd_o),
   .rxd_oe_o(rxd_oe_o), .tx_flag_o(tx_flag_o), .tx_flag_clr_i(tx_flag_clr_i),
   .rx_flag_o(rx_flag_o), .rx_flag_clr_i(rx_flag_clr_i),
   .rx_data_o(rx_data_o), .tx_busy(tx_busy)
);

// File: tb/test_serial_port_ctl.sv
module test_serial_port_ctl;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_i = 2'd1;
   logic       dbl_rate_i = 1'b1;
   logic [7:0] reload_i = 8'd255;
   logic       rx_en_i = 1'b1;
   logic       tx_wr_i = 1'b0;
   logic [7:0] tx_data_i = 8'h00;
   logic       tx_bit9_i = 1'b0;
   logic       tx_flag_clr_i = 1'b0;
   logic       rx_flag_clr_i = 1'b0;
   logic       rxd_i = 1'b1;
   logic       txd_o, rxd_o, rxd_oe_o, rx_bit9_o, tx_flag_o, rx_flag_o;
   logic [7:0] rx_data_o;

   int n_chk = 0;
   int n_err = 0;
   int tb = 192;
   int tx_frames = 0;
   int tx_pushed = 0;
   int rx_seen = 0;
   bit hold_ri = 0;
   logic [8:0] txq[$];
   logic [9:0] rxq[$];
   logic [8:0] got;
   logic [8:0] txe;
   logic [9:0] rxe;
   logic [7:0] last_good = 8'h00;
   time t_prev, t_now;

   always #(CLK_P / 2) clk = ~clk;

   serial_port_ctl i_serial_port_ctl (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dbl_rate_i(dbl_rate_i),
      .reload_i(reload_i), .rx_en_i(rx_en_i), .tx_wr_i(tx_wr_i),
      .tx_data_i(tx_data_i), .tx_bit9_i(tx_bit9_i),
      .tx_flag_clr_i(tx_flag_clr_i), .rx_flag_clr_i(rx_flag_clr_i),
      .rxd_i(rxd_i), .txd_o(txd_o), .rxd_o(rxd_o), .rxd_oe_o(rxd_oe_o),
      .rx_data_o(rx_data_o), .rx_bit9_o(rx_bit9_o),
      .tx_flag_o(tx_flag_o), .rx_flag_o(rx_flag_o)
   );

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [1:0] m, input logic d, input logic [7:0] n);
      @(negedge clk);
      mode_i = m;
      dbl_rate_i = d;
      reload_i = n;
      if (m == 2'd0)      tb = 64;
      else if (m == 2'd2) tb = d ? 32 : 64;
      else                tb = 12 * (256 - int'(n)) * (d ? 16 : 32);
      wait_clks(4000);
   endtask

   task automatic send_tx(input logic [7:0] d, input logic b9);
      @(negedge clk);
      tx_flag_clr_i = 1'b1;
      @(negedge clk);
      tx_flag_clr_i = 1'b0;
      check(tx_flag_o == 1'b0, "R7 flag cleared by strobe", 32'(tx_flag_o), 0);
      txq.push_back({b9, d});
      tx_pushed++;
      tx_data_i = d;
      tx_bit9_i = b9;
      tx_wr_i = 1'b1;
      @(negedge clk);
      tx_wr_i = 1'b0;
      if (mode_i == 2'd0) wait_clks(8 * 12 + 20);
      else                wait_clks(13 * tb);
      check(tx_frames == tx_pushed, "R11 frame count", 32'(tx_frames), 32'(tx_pushed));
   endtask

   task automatic drive_rx(input logic [7:0] d, input logic b9, input logic stop_v,
                           input bit push);
      if (push) rxq.push_back({(mode_i >= 2'd2), b9, d});
      @(negedge clk);
      rxd_i = 1'b0;
      wait_clks(tb);
      for (int i = 0; i < 8; i++) begin
         rxd_i = d[i];
         wait_clks(tb);
      end
      if (mode_i >= 2'd2) begin
         rxd_i = b9;
         wait_clks(tb);
      end
      rxd_i = stop_v;
      if (push) begin
         wait_clks(tb / 4);
         check(rx_flag_o == 1'b0, "R7 receive flag low before mid-stop", 32'(rx_flag_o), 0);
         wait_clks(tb - tb / 4);
      end else begin
         wait_clks(tb);
      end
      if (!stop_v) wait_clks(tb);
      rxd_i = 1'b1;
      wait_clks(2 * tb);
   endtask

   // transmit monitor
   initial begin : tx_mon
      forever begin
         @(negedge txd_o);
         got = '0;
         if (mode_i == 2'd0) begin
            for (int i = 0; i < 8; i++) begin
               @(posedge txd_o);
               t_now = $time;
               #1;
               got[i] = rxd_o;
               check(rxd_oe_o == 1'b1, "R2 drive enable", 32'(rxd_oe_o), 1);
               if (i > 0)
                  check((t_now - t_prev) == 12 * CLK_P, "R2 shift clock period",
                        32'(t_now - t_prev), 32'(12 * CLK_P));
               t_prev = t_now;
            end
            wait_clks(8);
            check(tx_flag_o == 1'b1, "R2 flag after eighth bit", 32'(tx_flag_o), 1);
            check(rxd_oe_o == 1'b0, "R2 drive released", 32'(rxd_oe_o), 0);
            if (txq.size() == 0) check(0, "R11 unexpected frame", 32'(got), 0);
            else begin
               txe = txq.pop_front();
               check(got[7:0] == txe[7:0], "R2 shifted byte", 32'(got[7:0]), 32'(txe[7:0]));
            end
         end else begin
            automatic int nb = (mode_i == 2'd1) ? 10 : 11;
            wait_clks(tb / 2);
            check(txd_o == 1'b0, "R3 start bit low", 32'(txd_o), 0);
            for (int k = 1; k < nb; k++) begin
               wait_clks(tb);
               if (k == nb - 2)
                  check(tx_flag_o == 1'b0, "R7 flag low before stop", 32'(tx_flag_o), 0);
               if (k == nb - 1) begin
                  check(txd_o == 1'b1, "R3 stop bit high", 32'(txd_o), 1);
                  check(tx_flag_o == 1'b1, "R7 flag at stop start", 32'(tx_flag_o), 1);
               end else if (k <= 8) got[k-1] = txd_o;
               else got[8] = txd_o;
            end
            if (txq.size() == 0) check(0, "R11 unexpected frame", 32'(got), 0);
            else begin
               txe = txq.pop_front();
               if (mode_i == 2'd1)
                  check(got[7:0] == txe[7:0], "R3 mode1 byte at timer rate R6",
                        32'(got[7:0]), 32'(txe[7:0]));
               else if (mode_i == 2'd2)
                  check(got[7:0] == txe[7:0], "R5 mode2 byte at fixed rate",
                        32'(got[7:0]), 32'(txe[7:0]));
               else
                  check(got[7:0] == txe[7:0], "R6 mode3 byte at timer rate",
                        32'(got[7:0]), 32'(txe[7:0]));
               if (mode_i != 2'd1)
                  check(got[8] == txe[8], "R4 ninth bit sent", 32'(got[8]), 32'(txe[8]));
            end
         end
         tx_frames++;
      end
   end

   // receive monitor
   initial begin : rx_mon
      forever begin
         @(posedge rx_flag_o);
         @(negedge clk);
         rx_seen++;
         if (rxq.size() == 0) check(0, "R9 unexpected reception", 32'(rx_data_o), 0);
         else begin
            rxe = rxq.pop_front();
            check(rx_data_o == rxe[7:0], "R3 received byte", 32'(rx_data_o), 32'(rxe[7:0]));
            if (rxe[9])
               check(rx_bit9_o == rxe[8], "R4 ninth bit received", 32'(rx_bit9_o), 32'(rxe[8]));
            last_good = rxe[7:0];
         end
         if (!hold_ri) begin
            rx_flag_clr_i = 1'b1;
            @(negedge clk);
            rx_flag_clr_i = 1'b0;
         end
      end
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      check(0, "watchdog run not finished", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      int seen0;
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(1);
      check(txd_o == 1'b1, "R1 txd idle", 32'(txd_o), 1);
      check(rxd_o == 1'b1 && rxd_oe_o == 1'b0, "R1 data line idle",
            32'({rxd_o, rxd_oe_o}), 32'h2);
      check(tx_flag_o == 1'b0 && rx_flag_o == 1'b0, "R1 flags clear",
            32'({tx_flag_o, rx_flag_o}), 0);
      check(rx_data_o == 8'h00, "R1 rx data", 32'(rx_data_o), 0);

      // mode 1, N=255, doubled: 192-clock bits
      set_cfg(2'd1, 1'b1, 8'd255);
      send_tx(8'hA5, 1'b0);
      send_tx(8'h3C, 1'b1);
      seen0 = rx_seen;
      drive_rx(8'h96, 1'b0, 1'b1, 1);
      check(rx_seen == seen0 + 1, "R3 frame received", 32'(rx_seen), 32'(seen0 + 1));

      // R7 flag holds until cleared
      hold_ri = 1;
      drive_rx(8'h2B, 1'b0, 1'b1, 1);
      wait_clks(3 * tb);
      check(rx_flag_o == 1'b1, "R7 receive flag held", 32'(rx_flag_o), 1);
      @(negedge clk);
      rx_flag_clr_i = 1'b1;
      @(negedge clk);
      rx_flag_clr_i = 1'b0;
      check(rx_flag_o == 1'b0, "R7 receive flag cleared", 32'(rx_flag_o), 0);
      hold_ri = 0;

      // R11 write during a frame
      @(negedge clk);
      tx_flag_clr_i = 1'b1;
      @(negedge clk);
      tx_flag_clr_i = 1'b0;
      txq.push_back({1'b0, 8'h5E});
      tx_pushed++;
      tx_data_i = 8'h5E;
      tx_wr_i = 1'b1;
      @(negedge clk);
      tx_wr_i = 1'b0;
      wait_clks(3 * tb);
      tx_data_i = 8'hFF;
      tx_wr_i = 1'b1;
      @(negedge clk);
      tx_wr_i = 1'b0;
      wait_clks(12 * tb);
      check(tx_frames == tx_pushed, "R11 write while busy ignored", 32'(tx_frames), 32'(tx_pushed));
      check(txd_o == 1'b1, "R11 line idle after frame", 32'(txd_o), 1);

      // mode 3, N=254, doubled: 384-clock bits
      set_cfg(2'd3, 1'b1, 8'd254);
      send_tx(8'h5A, 1'b1);
      send_tx(8'hC3, 1'b0);
      drive_rx(8'h71, 1'b1, 1'b1, 1);
      // mode 1 reception leaves ninth bit as is
      set_cfg(2'd1, 1'b1, 8'd255);
      drive_rx(8'h0C, 1'b0, 1'b1, 1);
      check(rx_bit9_o == 1'b1, "R4 ninth bit kept in mode 1", 32'(rx_bit9_o), 1);

      // mode 3, N=255, not doubled: 384-clock bits
      set_cfg(2'd3, 1'b0, 8'd255);
      send_tx(8'h81, 1'b1);
      drive_rx(8'h3D, 1'b0, 1'b1, 1);

      // mode 2 both rates
      set_cfg(2'd2, 1'b0, 8'd255);
      send_tx(8'hF0, 1'b1);
      drive_rx(8'h0F, 1'b0, 1'b1, 1);
      set_cfg(2'd2, 1'b1, 8'd255);
      send_tx(8'h12, 1'b0);
      drive_rx(8'hED, 1'b1, 1'b1, 1);

      // R8 false start then a good frame
      seen0 = rx_seen;
      @(negedge clk);
      rxd_i = 1'b0;
      wait_clks(tb / 4);
      rxd_i = 1'b1;
      wait_clks(3 * tb);
      check(rx_flag_o == 1'b0 && rx_seen == seen0, "R8 false start rejected",
            32'(rx_seen), 32'(seen0));
      drive_rx(8'h44, 1'b0, 1'b1, 1);
      check(rx_seen == seen0 + 1, "R8 frame after false start", 32'(rx_seen), 32'(seen0 + 1));

      // R9 low stop bit
      seen0 = rx_seen;
      drive_rx(8'h99, 1'b1, 1'b0, 0);
      check(rx_seen == seen0 && rx_flag_o == 1'b0, "R9 framing error dropped",
            32'(rx_seen), 32'(seen0));
      check(rx_data_o == last_good, "R9 data unchanged", 32'(rx_data_o), 32'(last_good));

      // R10 receive disabled
      rx_en_i = 1'b0;
      drive_rx(8'h66, 1'b0, 1'b1, 0);
      check(rx_seen == seen0 && rx_data_o == last_good, "R10 disabled receiver",
            32'(rx_data_o), 32'(last_good));
      rx_en_i = 1'b1;

      // mode 0 shift out, line activity ignored
      set_cfg(2'd0, 1'b0, 8'd255);
      send_tx(8'hB4, 1'b0);
      send_tx(8'h01, 1'b0);
      drive_rx(8'h55, 1'b0, 1'b1, 0);
      check(rx_seen == seen0 && rx_data_o == last_good, "R10 no reception in mode 0",
            32'(rx_data_o), 32'(last_good));

      wait_clks(20);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule